// File: doc/BRIEF.md
# Token Copy and Delete Cell

This block is a clocked version of the lattice cell that changes how many tokens circulate in a token-flow network. It holds one token from a data input and one from a control input. Once both are present, the control value decides the action. A control of 0 sends the data token on unchanged. A control of 1 either emits a duplicate while keeping the data token (copy mode), or removes the data token with no output (delete mode).

The cell drives up to `NUM_DIR` directional outputs. Each output has its own single-token slot with a valid/ready handshake, and a static enable mask selects the directions in use. A token that is emitted is written into every enabled direction at once. A static 3-bit cell-type code selects the mode. The cell acts only when every enabled output slot is empty, so a slow consumer stalls the cell without losing tokens.

Top module: `tokcd_cell`

## Requirements
- R1: After reset, `din_ready` and `ctl_ready` are 1 and every bit of `tok_valid` is 0.
- R2: An input slot accepts a token only when empty (`*_ready` is 1). While it holds a token its ready is 0.
- R3: The cell never emits while it is missing the data token or the control token.
- R4: While any enabled output still holds a token, the cell does not act and both held input tokens stay.
- R5: With control bit 0, in either mode, the data bit appears unchanged on every enabled output, and both input slots are freed in the same action.
- R6: In copy mode (`cell_code` = 3'b101) with control bit 1, the data bit is emitted on every enabled output. Only the control token is consumed, the data token stays (`din_ready` stays 0), and each further control 1 emits another copy.
- R7: In delete mode (`cell_code` = 3'b110) with control bit 1, both input tokens are consumed in one action and no output valid rises.
- R8: An output whose `out_en` bit is 0 never raises `tok_valid`.
- R9: An output token stays valid with a stable bit until its `tok_ready` is 1.
- R10: Any `cell_code` other than 3'b101 or 3'b110 prevents every action, and held tokens remain held.
- R11: When both inputs are accepted on clock edge A and the outputs are empty, the outputs become valid after edge A+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_code | input | 3 | Static cell type: 3'b101 copy, 3'b110 delete, others idle |
| out_en | input | NUM_DIR | Static mask of driven output directions |
| din_valid | input | 1 | Data token offered |
| din_bit | input | 1 | Data token value |
| din_ready | output | 1 | Data slot empty and able to accept |
| ctl_valid | input | 1 | Control token offered |
| ctl_bit | input | 1 | Control token value |
| ctl_ready | output | 1 | Control slot empty and able to accept |
| tok_valid | output | NUM_DIR | Output token present per direction |
| tok_bit | output | NUM_DIR | Output token value per direction |
| tok_ready | input | NUM_DIR | Downstream consumer takes the token per direction |

## Verification
On every cycle the assertions check several relations. Held output tokens do not move or change. Disabled directions stay quiet. A busy output or an unknown cell code freezes the held input tokens. A copy firing leaves the data token in place, and a delete firing clears both slots with no output. The control-0 pass in both modes, repeated copies from one data token, and the one-cycle spacing between acceptance and emission are shown only by the bench scenarios. The bench also compares against a behavioural token model cycle by cycle under random traffic and back-pressure.

// File: rtl/tokcd_pkg.sv
package tokcd_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_COPY   = 3'b101;
  localparam logic [CODE_W-1:0] CODE_DELETE = 3'b110;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PASS = 2'd1,
    ACT_DUP  = 2'd2,
    ACT_DROP = 2'd3
  } act_e;
endpackage

// File: rtl/tokcd_slot.sv
module tokcd_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_bit,
  input  logic consume,
  output logic held,
  output logic held_bit
);
  logic held_nxt;
  logic bit_en;

  always_comb begin
    held_nxt = held;
    if (consume) held_nxt = 1'b0;
    if (load)    held_nxt = 1'b1;
    bit_en = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_bit <= 1'b0;
    end else begin
      held <= held_nxt;
      if (bit_en) held_bit <= load_bit;
    end
  end
endmodule

// File: rtl/tokcd_fire.sv
module tokcd_fire
  import tokcd_pkg::*;
(
  input  logic [CODE_W-1:0] cell_code,
  input  logic              d_held,
  input  logic              c_held,
  input  logic              c_bit,
  input  logic              outs_busy,
  output act_e              act,
  output logic              emit,
  output logic              take_d,
  output logic              take_c
);
  logic code_ok;
  logic ready_all;

  always_comb begin
    code_ok   = (cell_code == CODE_COPY) || (cell_code == CODE_DELETE);
    ready_all = d_held && c_held && !outs_busy && code_ok;
    if (!ready_all)                   act = ACT_NONE;
    else if (!c_bit)                  act = ACT_PASS;
    else if (cell_code == CODE_COPY)  act = ACT_DUP;
    else                              act = ACT_DROP;
    emit   = (act == ACT_PASS) || (act == ACT_DUP);
    take_d = (act == ACT_PASS) || (act == ACT_DROP);
    take_c = (act != ACT_NONE);
  end
endmodule

// File: rtl/tokcd_outslot.sv
module tokcd_outslot (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic emit_bit,
  input  logic ready,
  output logic valid,
  output logic tbit
);
  logic valid_nxt;

  always_comb begin
    valid_nxt = valid;
    if (emit)               valid_nxt = 1'b1;
    else if (valid && ready) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tbit  <= 1'b0;
    end else begin
      valid <= valid_nxt;
      if (emit) tbit <= emit_bit;
    end
  end
endmodule

// File: rtl/tokcd_cell.sv
module tokcd_cell
  import tokcd_pkg::*;
#(
  parameter int NUM_DIR = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cell_code,
  input  logic [NUM_DIR-1:0] out_en,
  input  logic               din_valid,
  input  logic               din_bit,
  output logic               din_ready,
  input  logic               ctl_valid,
  input  logic               ctl_bit,
  output logic               ctl_ready,
  output logic [NUM_DIR-1:0] tok_valid,
  output logic [NUM_DIR-1:0] tok_bit,
  input  logic [NUM_DIR-1:0] tok_ready
);
  localparam int SYNC_LEN = 2;

  logic [SYNC_LEN-1:0] rst_pipe;
  logic rst_q_n;
  logic d_held, d_bit, c_held, c_bit;
  logic outs_busy, emit, take_d, take_c;
  act_e act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_LEN-1];

  assign din_ready = rst_q_n && !d_held;
  assign ctl_ready = rst_q_n && !c_held;
  assign outs_busy = |(tok_valid & out_en);

  tokcd_slot d_slot_i (
    .clk(clk), .rst_n(rst_q_n),
    .load(din_valid && din_ready), .load_bit(din_bit),
    .consume(take_d), .held(d_held), .held_bit(d_bit)
  );

  tokcd_slot c_slot_i (
    .clk(clk), .rst_n(rst_q_n),
    .load(ctl_valid && ctl_ready), .load_bit(ctl_bit),
    .consume(take_c), .held(c_held), .held_bit(c_bit)
  );

  tokcd_fire fire_i (
    .cell_code(cell_code), .d_held(d_held), .c_held(c_held),
    .c_bit(c_bit), .outs_busy(outs_busy), .act(act),
    .emit(emit), .take_d(take_d), .take_c(take_c)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    tokcd_outslot out_i (
      .clk(clk), .rst_n(rst_q_n),
      .emit(emit && out_en[g]), .emit_bit(d_bit),
      .ready(tok_ready[g]), .valid(tok_valid[g]), .tbit(tok_bit[g])
    );
  end
endmodule

// File: rtl/tokcd_cell_chk.sv
module tokcd_cell_chk
  import tokcd_pkg::*;
#(
  parameter int NUM_DIR = 6
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic [2:0]         cell_code,
  input logic [NUM_DIR-1:0] out_en,
  input logic               din_valid,
  input logic               din_ready,
  input logic               ctl_valid,
  input logic               ctl_ready,
  input logic [NUM_DIR-1:0] tok_valid,
  input logic [NUM_DIR-1:0] tok_bit,
  input logic [NUM_DIR-1:0] tok_ready,
  input logic               d_held,
  input logic               c_held,
  input logic               c_bit
);
  logic busy;
  logic code_ok;
  assign busy    = |(tok_valid & out_en);
  assign code_ok = (cell_code == CODE_COPY) || (cell_code == CODE_DELETE);

  a_r2_data_full: assert property (@(posedge clk) disable iff (!rst_q_n)
    (din_valid && din_ready) |=> !din_ready);
  a_r2_ctl_full: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl_valid && ctl_ready) |=> !ctl_ready);
  a_r3_no_lone_fire: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((!d_held || !c_held) && tok_valid == '0) |=> tok_valid == '0);
  a_r4_busy_waits: assert property (@(posedge clk) disable iff (!rst_q_n)
    (d_held && c_held && busy) |=> (d_held && c_held));
  a_r6_copy_keeps: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cell_code == CODE_COPY && d_held && c_held && c_bit && !busy)
      |=> (d_held && !c_held && tok_valid == out_en));
  a_r7_delete_silent: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cell_code == CODE_DELETE && d_held && c_held && c_bit && !busy)
      |=> (!d_held && !c_held && tok_valid == '0));
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tok_valid & ~out_en) == '0);
  a_r10_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!code_ok && d_held) |=> d_held);

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_hold
    a_r9_hold_token: assert property (@(posedge clk) disable iff (!rst_q_n)
      (tok_valid[g] && !tok_ready[g]) |=> (tok_valid[g] && $stable(tok_bit[g])));
  end
endmodule

bind tokcd_cell tokcd_cell_chk #(.NUM_DIR(NUM_DIR)) chk_i (
  .clk(clk), .rst_q_n(rst_q_n), .cell_code(cell_code), .out_en(out_en),
  .din_valid(din_valid), .din_ready(din_ready),
  .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
  .tok_valid(tok_valid), .tok_bit(tok_bit), .tok_ready(tok_ready),
  .d_held(d_held), .c_held(c_held), .c_bit(c_bit)
);

// File: tb/tokcd_cell_tb_top.sv
module tokcd_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 6;
  localparam logic [2:0] CP = 3'b101;
  localparam logic [2:0] DL = 3'b110;
  localparam logic [ND-1:0] EN = 6'b100101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cell_code = CP;
  logic [ND-1:0] out_en = EN;
  logic din_valid = 1'b0, din_bit = 1'b0, ctl_valid = 1'b0, ctl_bit = 1'b0;
  logic din_ready, ctl_ready;
  logic [ND-1:0] tok_valid, tok_bit;
  logic [ND-1:0] tok_ready = '1;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tokcd_cell #(.NUM_DIR(ND)) dut_i (
    .clk(clk), .rst_n(rst_n), .cell_code(cell_code), .out_en(out_en),
    .din_valid(din_valid), .din_bit(din_bit), .din_ready(din_ready),
    .ctl_valid(ctl_valid), .ctl_bit(ctl_bit), .ctl_ready(ctl_ready),
    .tok_valid(tok_valid), .tok_bit(tok_bit), .tok_ready(tok_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural token model
  bit dq[$];
  bit cq[$];
  int ov[ND];
  int ob[ND];
  int m1 = 0, m2 = 0;

  always @(posedge clk) begin : model
    bit busy, fire, emit, tk_d, tk_c, ebit, acc_d, acc_c;
    if (!rst_n || m2 == 0) begin
      dq.delete(); cq.delete();
      for (int i = 0; i < ND; i++) begin ov[i] = 0; ob[i] = 0; end
    end else begin
      busy = 0;
      for (int i = 0; i < ND; i++) if (out_en[i] && ov[i] != 0) busy = 1;
      fire = dq.size() > 0 && cq.size() > 0 && !busy && (cell_code == CP || cell_code == DL);
      emit = 0; tk_d = 0; tk_c = 0; ebit = 0;
      if (fire) begin
        ebit = dq[0];
        tk_c = 1;
        if (cq[0] == 1'b0) begin emit = 1; tk_d = 1; end
        else if (cell_code == CP) emit = 1;
        else tk_d = 1;
      end
      acc_d = din_valid && dq.size() == 0;
      acc_c = ctl_valid && cq.size() == 0;
      for (int i = 0; i < ND; i++) begin
        if (emit && out_en[i]) begin ov[i] = 1; ob[i] = ebit; end
        else if (ov[i] != 0 && tok_ready[i]) ov[i] = 0;
      end
      if (tk_d) void'(dq.pop_front());
      if (tk_c) void'(cq.pop_front());
      if (acc_d) dq.push_back(din_bit);
      if (acc_c) cq.push_back(ctl_bit);
    end
    if (!rst_n) begin m1 = 0; m2 = 0; end
    else begin m2 = m1; m1 = 1; end
  end

  always @(negedge clk) begin : compare
    logic [ND-1:0] ev;
    if (cmp_on) begin
      for (int i = 0; i < ND; i++) ev[i] = (ov[i] != 0);
      chk("R11 model din_ready", din_ready, (m2 != 0) && dq.size() == 0);
      chk("R11 model ctl_ready", ctl_ready, (m2 != 0) && cq.size() == 0);
      chk("R11 model tok_valid", tok_valid, ev);
      for (int i = 0; i < ND; i++)
        if (ev[i]) chk("R5 model tok_bit", tok_bit[i], ob[i][0]);
    end
  end

  task automatic put_both(input bit db, input bit cb);
    @(negedge clk);
    din_valid = 1; din_bit = db; ctl_valid = 1; ctl_bit = cb;
    @(negedge clk);
    din_valid = 0; ctl_valid = 0;
  endtask

  task automatic put_data(input bit db);
    @(negedge clk);
    din_valid = 1; din_bit = db;
    @(negedge clk);
    din_valid = 0;
  endtask

  task automatic put_ctl(input bit cb);
    @(negedge clk);
    ctl_valid = 1; ctl_bit = cb;
    @(negedge clk);
    ctl_valid = 0;
  endtask

  function automatic logic [ND-1:0] rep(input bit b);
    return b ? EN : '0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk("R1 din_ready", din_ready, 1);
    chk("R1 ctl_ready", ctl_ready, 1);
    chk("R1 tok_valid", tok_valid, 0);

    // R5/R11 pass in copy mode
    cell_code = CP;
    put_both(1, 0);
    chk("R11 not yet valid", tok_valid, 0);
    @(negedge clk);
    chk("R5 copy-mode pass valid", tok_valid, EN);
    chk("R5 copy-mode pass bit", tok_bit & EN, rep(1));
    chk("R5 data freed", din_ready, 1);
    chk("R8 disabled quiet", tok_valid & ~EN, 0);

    // R5 pass in delete mode
    cell_code = DL;
    put_both(1, 0);
    @(negedge clk);
    chk("R5 delete-mode pass valid", tok_valid, EN);
    chk("R5 delete-mode pass bit", tok_bit & EN, rep(1));

    // R6 copy repeats
    cell_code = CP;
    put_both(1, 1);
    @(negedge clk);
    chk("R6 copy valid", tok_valid, EN);
    chk("R6 copy bit", tok_bit & EN, rep(1));
    chk("R6 data kept", din_ready, 0);
    chk("R6 control used", ctl_ready, 1);
    put_ctl(1);
    @(negedge clk);
    chk("R6 second copy", tok_valid, EN);
    chk("R6 data still kept", din_ready, 0);
    put_ctl(0);
    @(negedge clk);
    chk("R6 final pass", tok_valid, EN);
    chk("R6 data released", din_ready, 1);

    // R7 delete
    cell_code = DL;
    put_both(1, 1);
    @(negedge clk);
    chk("R7 no output", tok_valid, 0);
    chk("R7 data consumed", din_ready, 1);
    chk("R7 control consumed", ctl_ready, 1);
    @(negedge clk);
    chk("R7 still no output", tok_valid, 0);

    // R4/R9 back-pressure
    cell_code = CP;
    tok_ready = '0;
    put_both(0, 1);
    @(negedge clk);
    chk("R4 first copy", tok_valid, EN);
    put_ctl(1);
    repeat (3) @(negedge clk);
    chk("R4 control waits", ctl_ready, 0);
    chk("R9 token held", tok_valid, EN);
    chk("R9 bit held", tok_bit & EN, rep(0));
    tok_ready = '1;
    @(negedge clk);
    chk("R9 drained", tok_valid, 0);
    @(negedge clk);
    chk("R4 fires after drain", tok_valid, EN);
    chk("R4 control freed", ctl_ready, 1);
    put_ctl(0);
    @(negedge clk);
    chk("R4 final pass", tok_valid, EN);
    chk("R4 data released", din_ready, 1);

    // R3 lone tokens, R2 slot full
    put_data(1);
    chk("R2 data slot full", din_ready, 0);
    repeat (3) @(negedge clk);
    chk("R3 no fire without control", tok_valid, 0);
    put_ctl(0);
    @(negedge clk);
    chk("R3 fires once both held", tok_valid, EN);
    put_ctl(1);
    chk("R2 control slot full", ctl_ready, 0);
    repeat (3) @(negedge clk);
    chk("R3 no fire without data", tok_valid, 0);
    cell_code = DL;
    put_data(0);
    @(negedge clk);
    chk("R3 delete after both", tok_valid, 0);
    chk("R3 slots empty", {din_ready, ctl_ready}, 2'b11);

    // R10 unknown code
    cell_code = 3'b000;
    put_both(1, 0);
    repeat (3) @(negedge clk);
    chk("R10 no output", tok_valid, 0);
    chk("R10 tokens held", {din_ready, ctl_ready}, 2'b00);
    cell_code = CP;
    @(negedge clk);
    chk("R10 fires once code valid", tok_valid, EN);
    chk("R10 bit", tok_bit & EN, rep(1));

    // random traffic against model
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (n == 300) cell_code = DL;
      din_valid = lf[0]; din_bit = lf[1];
      ctl_valid = lf[2]; ctl_bit = lf[3] & lf[4];
      tok_ready = lf[10:5] | lf[15:10];
    end
    @(negedge clk);
    din_valid = 0; ctl_valid = 0; tok_ready = '1;
    repeat (10) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule